// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. Each cycle in which `issue_i` is high, it takes an accumulator value, a second operand and an operation code. It computes a result, decides whether that result should be written back to the accumulator, and updates a five-flag status word. It keeps the status word in its own register. Operations that depend on carry or on the nibble carry (add/subtract with carry, through-carry rotates, decimal adjust) read the flags left by the previous operation. The result, the write-enable and the flags all appear one clock after the operation is issued, so operations can be issued back to back.

Fetching, decoding, the register file and memory traffic are handled outside this block. The surrounding datapath feeds the current accumulator value in with every operation. It writes `res_o` back into the accumulator when `acc_we_o` is high.

Top module: `acc_alu`

## Requirements
- R1: After reset, `res_o` is 0x00, `acc_we_o` is 0 and `flags_o` is 0x02. The flag word layout is sign at bit 7, zero at bit 6, nibble carry (AC) at bit 4, parity at bit 2 and carry (CY) at bit 0. Bit 1 always reads 1, and bits 5 and 3 always read 0.
- R2: Op code 0 (add) gives acc+opnd. Op code 1 (add-with-carry) gives acc+opnd+CY. CY becomes the carry out of bit 7 and AC the carry out of bit 3. The result is written back.
- R3: Op code 2 (subtract) gives acc-opnd. Op code 3 (subtract-with-borrow) gives acc-opnd-CY. CY becomes 1 when a borrow leaves bit 7, and AC becomes 1 when a borrow leaves the low nibble. The result is written back.
- R4: Op code 4 (compare) sets every flag exactly as subtract would. `res_o` shows the difference, but `acc_we_o` stays 0.
- R5: For every operation that updates them (R2, R3, R4, R6, R10, R11), sign copies result bit 7, zero is 1 when the result is 0x00, and parity is 1 when the result holds an even number of ones.
- R6: Op codes 5, 6 and 7 give acc AND opnd, acc OR opnd and acc XOR opnd. AND sets AC to 1. OR and XOR clear AC. All three clear CY.
- R7: Op code 8 rotates left with bit 7 going to bit 0 and to CY. Op code 9 rotates right with bit 0 going to bit 7 and to CY. Op code 10 rotates left through carry (old CY to bit 0, bit 7 to CY). Op code 11 rotates right through carry (old CY to bit 7, bit 0 to CY). Only CY changes among the flags, and the result is written back.
- R8: Op code 12 writes the bitwise inverse of the accumulator and leaves all flags unchanged.
- R9: Op code 13 inverts CY and op code 14 sets CY to 1. No other flag changes, `acc_we_o` is 0 and `res_o` shows the accumulator input.
- R10: Op code 15 gives acc+1 with AC set when the low nibble was 0xF. Op code 16 gives acc-1 with AC set when the low nibble was 0x0. Both leave CY unchanged and write the result.
- R11: Op code 17 (decimal adjust) first adds 0x06 when the low nibble exceeds 9 or AC is set, and AC becomes the carry out of that nibble addition. It then adds 0x60 when the resulting high nibble exceeds 9, CY is set, or the first step carried out of bit 7. CY becomes 1 if this second correction was applied and otherwise keeps its value. The result is written back.
- R12: Outputs are registered, and an issued operation is visible on the ports one clock later. A cycle with `issue_i` low gives `acc_we_o` 0 and holds `res_o` and `flags_o`. Op codes 18 to 31 give `acc_we_o` 0, unchanged flags and `res_o` equal to the accumulator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand |
| res_o | output | 8 | Registered result |
| acc_we_o | output | 1 | Write the result back into the accumulator |
| flags_o | output | 8 | Registered status flag word |

## Verification
The stimulus chains operations so that each one depends on carry and nibble-carry values produced by the operation before it. A design that computed the nibble borrow backwards, or that dropped the incoming carry in add-with-carry or subtract-with-borrow, would show the wrong AC or result on the very next vector. Decimal adjust is driven into three distinct paths: a correction forced only by the flags, a low-nibble-only correction, and a double correction that overflows. A design that tested the high nibble before the low correction, or that cleared CY when no high correction was applied, diverges on one of those paths. Compare, carry-only operations and unassigned codes are checked for a silent write-back. Increment, decrement and complement are checked for disturbing a carry the bench set up beforehand.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 8;

    // flag word bit positions (fixed: read by neighbouring logic)
    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_AC = 4;
    localparam int FB_P  = 2;
    localparam int FB_CY = 0;

    localparam logic [FLAG_W-1:0] FLAG_RST = 8'h02;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_CMP = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_XOR = 5'd7,
        OP_RLC = 5'd8,
        OP_RRC = 5'd9,
        OP_RAL = 5'd10,
        OP_RAR = 5'd11,
        OP_CMA = 5'd12,
        OP_CMC = 5'd13,
        OP_STC = 5'd14,
        OP_INR = 5'd15,
        OP_DCR = 5'd16,
        OP_DAA = 5'd17
    } alu_op_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] res_o,
    output logic          co_o,
    output logic          hco_o
);
    localparam int HW = DW / 2;

    logic [DW:0] full_d;
    logic [HW:0] half_d;

    always_comb begin
        if (sub_i) begin
            full_d = {1'b0, a_i} - {1'b0, b_i} - (DW+1)'(cin_i);
            half_d = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - (HW+1)'(cin_i);
        end else begin
            full_d = {1'b0, a_i} + {1'b0, b_i} + (DW+1)'(cin_i);
            half_d = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + (HW+1)'(cin_i);
        end
        res_o = full_d[DW-1:0];
        co_o  = full_d[DW];
        hco_o = half_d[HW];
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cy_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        case (op_i)
            OP_AND: begin res_o = a_i & b_i; cy_o = 1'b0; end
            OP_OR:  begin res_o = a_i | b_i; cy_o = 1'b0; end
            OP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; end
            OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
            OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
            OP_RAL: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
            OP_RAR: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
            OP_CMA: begin res_o = ~a_i; end
            default: begin res_o = a_i; cy_o = cy_i; end
        endcase
    end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic          ac_i,
    input  logic          cy_i,
    output logic [DW-1:0] res_o,
    output logic          ac_o,
    output logic          cy_o
);
    localparam int HW = DW / 2;
    localparam logic [HW-1:0] DIGIT_MAX = HW'(9);
    localparam logic [DW:0]   FIX_LO    = (DW+1)'(6);
    localparam logic [DW-1:0] FIX_HI    = DW'(6) << HW;

    logic          lo_fix, hi_fix;
    logic [HW:0]   nib_sum;
    logic [DW:0]   step1;
    logic [DW-1:0] step2;

    always_comb begin
        lo_fix  = (a_i[HW-1:0] > DIGIT_MAX) || ac_i;
        nib_sum = {1'b0, a_i[HW-1:0]} + FIX_LO[HW:0];
        step1   = {1'b0, a_i} + (lo_fix ? FIX_LO : '0);
        hi_fix  = (step1[DW-1:HW] > DIGIT_MAX) || cy_i || step1[DW];
        step2   = step1[DW-1:0] + (hi_fix ? FIX_HI : '0);
        res_o   = step2;
        ac_o    = lo_fix && nib_sum[HW];
        cy_o    = cy_i || hi_fix;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DW-1:0]     acc_i,
    input  logic [DW-1:0]     opnd_i,
    output logic [DW-1:0]     res_o,
    output logic              acc_we_o,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic [DW-1:0]     res;
        logic              we;
        logic [FLAG_W-1:0] flags;
    } alu_state_t;

    alu_state_t st_d, st_q;
    alu_op_e    op;

    logic [DW-1:0] as_b, as_res, bo_res, da_res;
    logic          as_cin, as_sub, as_co, as_hco, bo_cy, da_ac, da_cy;

    assign op = alu_op_e'(op_i);

    always_comb begin
        as_b   = (op == OP_INR || op == OP_DCR) ? DW'(1) : opnd_i;
        as_cin = (op == OP_ADC || op == OP_SBB) ? st_q.flags[FB_CY] : 1'b0;
        as_sub = (op == OP_SUB || op == OP_SBB || op == OP_CMP || op == OP_DCR);
    end

    acc_alu_addsub #(.DW(DW)) u_addsub (
        .a_i(acc_i), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
        .res_o(as_res), .co_o(as_co), .hco_o(as_hco)
    );

    acc_alu_bitops #(.DW(DW)) u_bitops (
        .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(st_q.flags[FB_CY]),
        .res_o(bo_res), .cy_o(bo_cy)
    );

    acc_alu_decadj #(.DW(DW)) u_decadj (
        .a_i(acc_i), .ac_i(st_q.flags[FB_AC]), .cy_i(st_q.flags[FB_CY]),
        .res_o(da_res), .ac_o(da_ac), .cy_o(da_cy)
    );

    function automatic logic [FLAG_W-1:0] put_szp(input logic [FLAG_W-1:0] f,
                                                  input logic [DW-1:0] r);
        logic [FLAG_W-1:0] o;
        o       = f;
        o[FB_S] = r[DW-1];
        o[FB_Z] = (r == '0);
        o[FB_P] = ~^r;
        return o;
    endfunction

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (issue_i) begin
            st_d.res = acc_i;
            case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                    st_d.res             = as_res;
                    st_d.we              = (op != OP_CMP);
                    st_d.flags           = put_szp(st_q.flags, as_res);
                    st_d.flags[FB_AC]    = as_hco;
                    st_d.flags[FB_CY]    = as_co;
                end
                OP_INR, OP_DCR: begin
                    st_d.res             = as_res;
                    st_d.we              = 1'b1;
                    st_d.flags           = put_szp(st_q.flags, as_res);
                    st_d.flags[FB_AC]    = as_hco;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.res             = bo_res;
                    st_d.we              = 1'b1;
                    st_d.flags           = put_szp(st_q.flags, bo_res);
                    st_d.flags[FB_AC]    = (op == OP_AND);
                    st_d.flags[FB_CY]    = bo_cy;
                end
                OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                    st_d.res             = bo_res;
                    st_d.we              = 1'b1;
                    st_d.flags[FB_CY]    = bo_cy;
                end
                OP_CMA: begin
                    st_d.res             = bo_res;
                    st_d.we              = 1'b1;
                end
                OP_CMC: st_d.flags[FB_CY] = ~st_q.flags[FB_CY];
                OP_STC: st_d.flags[FB_CY] = 1'b1;
                OP_DAA: begin
                    st_d.res             = da_res;
                    st_d.we              = 1'b1;
                    st_d.flags           = put_szp(st_q.flags, da_res);
                    st_d.flags[FB_AC]    = da_ac;
                    st_d.flags[FB_CY]    = da_cy;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.res   <= '0;
            st_q.we    <= 1'b0;
            st_q.flags <= FLAG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o    = st_q.res;
    assign acc_we_o = st_q.we;
    assign flags_o  = st_q.flags;

    // R4: compare never requests a write-back
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == OP_CMP) |=> !acc_we_o);

    // R6: logical operations clear carry
    a_r6_logic_clears_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=> !flags_o[FB_CY]);

    // R8: complementing the accumulator leaves the flag word intact
    a_r8_cma_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == OP_CMA) |=> $stable(flags_o));

    // R9: set-carry leaves carry at 1 and writes nothing
    a_r9_stc_sets_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == OP_STC) |=> (flags_o[FB_CY] && !acc_we_o));

    // R10: increment and decrement keep carry
    a_r10_incdec_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (op_i == OP_INR || op_i == OP_DCR)) |=> $stable(flags_o[FB_CY]));

    // R12: idle cycle holds state and drops the write-enable
    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!acc_we_o && $stable(flags_o) && $stable(res_o)));
endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [7:0] res_o;
    logic       acc_we_o;
    logic [7:0] flags_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5ns clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i),
        .res_o(res_o), .acc_we_o(acc_we_o), .flags_o(flags_o)
    );

    // {op, acc, opnd, exp_res, exp_we, exp_flags}; flags chain from vector to vector
    localparam int NV = 24;
    localparam logic [37:0] VEC [NV] = '{
        {5'd0,  8'h14, 8'h89, 8'h9D, 1'b1, 8'h82},
        {5'd0,  8'hFF, 8'h01, 8'h00, 1'b1, 8'h57},
        {5'd1,  8'h10, 8'h20, 8'h31, 1'b1, 8'h02},
        {5'd14, 8'h55, 8'h00, 8'h55, 1'b0, 8'h03},
        {5'd3,  8'h50, 8'h20, 8'h2F, 1'b1, 8'h12},
        {5'd2,  8'h05, 8'h07, 8'hFE, 1'b1, 8'h93},
        {5'd4,  8'h42, 8'h42, 8'h00, 1'b0, 8'h46},
        {5'd13, 8'h00, 8'h00, 8'h00, 1'b0, 8'h47},
        {5'd10, 8'h81, 8'h00, 8'h03, 1'b1, 8'h47},
        {5'd11, 8'h02, 8'h00, 8'h81, 1'b1, 8'h46},
        {5'd8,  8'h80, 8'h00, 8'h01, 1'b1, 8'h47},
        {5'd9,  8'h02, 8'h00, 8'h01, 1'b1, 8'h46},
        {5'd5,  8'hF0, 8'h3C, 8'h30, 1'b1, 8'h16},
        {5'd7,  8'hAA, 8'hFF, 8'h55, 1'b1, 8'h06},
        {5'd6,  8'h80, 8'h01, 8'h81, 1'b1, 8'h86},
        {5'd12, 8'h5A, 8'h00, 8'hA5, 1'b1, 8'h86},
        {5'd14, 8'h00, 8'h00, 8'h00, 1'b0, 8'h87},
        {5'd15, 8'hFF, 8'h00, 8'h00, 1'b1, 8'h57},
        {5'd16, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h97},
        {5'd17, 8'h00, 8'h00, 8'h66, 1'b1, 8'h07},
        {5'd0,  8'h38, 8'h45, 8'h7D, 1'b1, 8'h06},
        {5'd17, 8'h7D, 8'h00, 8'h83, 1'b1, 8'h92},
        {5'd17, 8'h9B, 8'h00, 8'h01, 1'b1, 8'h13},
        {5'd31, 8'h77, 8'h00, 8'h77, 1'b0, 8'h13}
    };

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:             return "R2";
            5'd2, 5'd3:             return "R3";
            5'd4:                   return "R4";
            5'd5, 5'd6, 5'd7:       return "R6";
            5'd8, 5'd9, 5'd10, 5'd11: return "R7";
            5'd12:                  return "R8";
            5'd13, 5'd14:           return "R9";
            5'd15, 5'd16:           return "R10";
            5'd17:                  return "R11";
            default:                return "R12";
        endcase
    endfunction

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check8("R1", "res", res_o, 8'h00);
        check8("R1", "we", {7'd0, acc_we_o}, 8'h00);
        check8("R1", "flags", flags_o, 8'h02);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1", "flags after release", flags_o, 8'h02);

        // table walk; flag-dependent vectors (R5 S/Z/P everywhere) chain in order
        for (int i = 0; i < NV; i++) begin
            op_i    = VEC[i][37:33];
            acc_i   = VEC[i][32:25];
            opnd_i  = VEC[i][24:17];
            issue_i = 1'b1;
            @(negedge clk);
            check8(req_of(VEC[i][37:33]), $sformatf("vec%0d res", i), res_o, VEC[i][16:9]);
            check8(req_of(VEC[i][37:33]), $sformatf("vec%0d we", i),
                   {7'd0, acc_we_o}, {7'd0, VEC[i][8]});
            check8(req_of(VEC[i][37:33]), $sformatf("vec%0d flags", i), flags_o, VEC[i][7:0]);
        end

        // R12 idle: inputs change but nothing is issued
        issue_i = 1'b0;
        op_i    = 5'd0;
        acc_i   = 8'hFF;
        opnd_i  = 8'hFF;
        @(negedge clk);
        check8("R12", "idle we", {7'd0, acc_we_o}, 8'h00);
        check8("R12", "idle res held", res_o, 8'h77);
        check8("R12", "idle flags held", flags_o, 8'h13);

        // R3 borrow out of bit 7 with borrow-in: 0x00 - 0x00 - CY(1) = 0xFF
        op_i = 5'd3; acc_i = 8'h00; opnd_i = 8'h00; issue_i = 1'b1;
        @(negedge clk);
        check8("R3", "sbb wrap res", res_o, 8'hFF);
        check8("R3", "sbb wrap flags", flags_o, 8'h97);

        // R1 reset mid-stream returns flags to their reset word
        issue_i = 1'b0;
        rst_n   = 1'b0;
        @(negedge clk);
        check8("R1", "re-reset flags", flags_o, 8'h02);
        check8("R1", "re-reset res", res_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule